// File: doc/BRIEF.md
# Synchronous Fault Redirect Unit

This unit sits beside the control state machine and ALU of a multicycle processor core and turns two synchronous faults into a redirect of the program counter. The first is an opcode that names no supported instruction, seen while the instruction is being decoded. The second is signed overflow from an add or subtract, seen while a register-to-register instruction is executing.

In the cycle a fault is seen, the unit drives a PC load request carrying the handler address for that fault. On the same clock edge it stores the faulting instruction's address and a fault code. The faulting address is the current PC less one instruction step, because fetch has already advanced the PC. The unit also blocks register-file writes in that cycle and the one after, so a result that overflowed never reaches a register. All control pins are plain level signals with no handshake. The unit cannot stall anything, so it has no back-pressure rules.

Top module: `exc_vector_unit`

## Requirements
- R1: After reset, `epc` and `cause` are zero and `pc_load` is low.
- R2: When `decode_stb` is high and `opcode` is not one of 0x00, 0x02, 0x04, 0x23 or 0x2B, `pc_load` is high in that same cycle and `pc_target` is 0xC000_0000.
- R3: When `decode_stb` is high with any of the five supported opcodes, no redirect occurs and `epc` and `cause` keep their values.
- R4: When `exec_stb` is high and `alu_op` is 1 (add), and `alu_a` and `alu_b` have the same sign but `alu_res` has the other sign, `pc_load` is high in that cycle and `pc_target` is 0xC000_0020.
- R5: When `exec_stb` is high and `alu_op` is 2 (subtract), and `alu_a` and `alu_b` differ in sign and `alu_res` differs in sign from `alu_a`, the overflow redirect of R4 occurs.
- R6: Overflow is ignored when `exec_stb` is low, or when `alu_op` is 0 or 3. In that case there is no redirect.
- R7: On the clock edge that ends a redirect cycle, `epc` takes `pc_now` minus 4. `cause` takes 0 for an undefined opcode and 1 for an overflow, held in bit 0, with bits 31..1 zero.
- R8: `rf_we_out` follows `rf_we_in`, except that it is forced low in a redirect cycle and in the cycle after it.
- R9: Outside redirect edges, `epc` and `cause` hold their values.
- R10: `opcode` is ignored while `decode_stb` is low.
- R11: If both faults occur in the same cycle, the undefined-opcode fault wins. The target is then 0xC000_0000 and the cause is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pc_now | input | 32 | Current PC, already advanced past the instruction |
| decode_stb | input | 1 | Control FSM is in its decode step |
| opcode | input | 6 | Opcode field of the instruction register |
| exec_stb | input | 1 | Control FSM is executing a register-to-register instruction |
| alu_op | input | 2 | ALU operation: 0 other, 1 add, 2 subtract, 3 other |
| alu_a | input | 32 | First ALU operand |
| alu_b | input | 32 | Second ALU operand |
| alu_res | input | 32 | ALU result |
| rf_we_in | input | 1 | Register write request from the FSM |
| pc_load | output | 1 | Load the PC with `pc_target` this edge |
| pc_target | output | 32 | Handler address for the fault |
| rf_we_out | output | 1 | Gated register write enable |
| epc | output | 32 | Address of the faulting instruction |
| cause | output | 32 | Fault code in bit 0 |

## Verification
The checker assumes the control FSM never raises `decode_stb` and `exec_stb` together except to exercise the priority rule. It also assumes `alu_res` is the true 32-bit wrapped sum or difference of the operands, so that the sign rules mean signed overflow. The bench computes every ALU result with plain wrapped arithmetic and drives strobes one phase at a time. The one exception is a deliberate collision case for R11. Inputs change only on the falling edge, so every value seen at a rising edge comes from a single, stable stimulus step.

// File: rtl/exc_pkg.sv
package exc_pkg;
  parameter int XLEN = 32;
  parameter int OPW  = 6;

  typedef enum logic [1:0] {
    ALU_OTHER = 2'd0,
    ALU_ADD   = 2'd1,
    ALU_SUB   = 2'd2,
    ALU_MISC  = 2'd3
  } alu_sel_e;

  typedef enum logic {
    CODE_BADOP = 1'b0,
    CODE_OVF   = 1'b1
  } fault_code_e;

  localparam int NLEGAL = 5;
  localparam logic [OPW-1:0] LEGAL_OPS [NLEGAL] = '{
    6'h00, 6'h02, 6'h04, 6'h23, 6'h2B
  };
endpackage

// File: rtl/exc_opcode_check.sv
module exc_opcode_check
  import exc_pkg::*;
#(
  parameter int W = OPW
) (
  input  logic         strobe,
  input  logic [W-1:0] opcode,
  output logic         bad_op
);
  logic [NLEGAL-1:0] hit;

  for (genvar i = 0; i < NLEGAL; i++) begin : g_cmp
    assign hit[i] = (opcode == LEGAL_OPS[i][W-1:0]);
  end

  assign bad_op = strobe && (hit == '0);
endmodule

// File: rtl/exc_ovf_detect.sv
module exc_ovf_detect
  import exc_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic         strobe,
  input  logic [1:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] res,
  output logic         ovf
);
  localparam int MSB = W - 1;

  logic sa, sb, sr, add_ovf, sub_ovf;

  always_comb begin
    sa      = a[MSB];
    sb      = b[MSB];
    sr      = res[MSB];
    add_ovf = (sa == sb) && (sr != sa);
    sub_ovf = (sa != sb) && (sr != sa);
    unique case (alu_sel_e'(op))
      ALU_ADD: ovf = strobe && add_ovf;
      ALU_SUB: ovf = strobe && sub_ovf;
      default: ovf = 1'b0;
    endcase
  end
endmodule

// File: rtl/exc_fault_regs.sv
module exc_fault_regs
  import exc_pkg::*;
#(
  parameter int W       = XLEN,
  parameter int PC_STEP = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         take,
  input  fault_code_e  code,
  input  logic [W-1:0] pc_now,
  output logic [W-1:0] epc,
  output logic [W-1:0] cause,
  output logic         kill_q
);
  localparam logic [W-1:0] STEP = W'(PC_STEP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      epc    <= '0;
      cause  <= '0;
      kill_q <= 1'b0;
    end else begin
      kill_q <= take;
      if (take) begin
        epc   <= pc_now - STEP;
        cause <= {{(W-1){1'b0}}, logic'(code)};
      end
    end
  end
endmodule

// File: rtl/exc_vector_unit.sv
module exc_vector_unit
  import exc_pkg::*;
#(
  parameter int              W         = XLEN,
  parameter int              OW        = OPW,
  parameter int              PC_STEP   = 4,
  parameter logic [W-1:0]    VEC_BADOP = 32'hC000_0000,
  parameter logic [W-1:0]    VEC_OVF   = 32'hC000_0020
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  pc_now,
  input  logic          decode_stb,
  input  logic [OW-1:0] opcode,
  input  logic          exec_stb,
  input  logic [1:0]    alu_op,
  input  logic [W-1:0]  alu_a,
  input  logic [W-1:0]  alu_b,
  input  logic [W-1:0]  alu_res,
  input  logic          rf_we_in,
  output logic          pc_load,
  output logic [W-1:0]  pc_target,
  output logic          rf_we_out,
  output logic [W-1:0]  epc,
  output logic [W-1:0]  cause
);
  logic        bad_op, ovf, kill_q;
  fault_code_e code;

  exc_opcode_check #(.W(OW)) u_opchk (
    .strobe (decode_stb),
    .opcode (opcode),
    .bad_op (bad_op)
  );

  exc_ovf_detect #(.W(W)) u_ovf (
    .strobe (exec_stb),
    .op     (alu_op),
    .a      (alu_a),
    .b      (alu_b),
    .res    (alu_res),
    .ovf    (ovf)
  );

  always_comb begin
    pc_load   = bad_op || ovf;
    code      = bad_op ? CODE_BADOP : CODE_OVF;
    pc_target = bad_op ? VEC_BADOP : (ovf ? VEC_OVF : '0);
  end

  exc_fault_regs #(.W(W), .PC_STEP(PC_STEP)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .take   (pc_load),
    .code   (code),
    .pc_now (pc_now),
    .epc    (epc),
    .cause  (cause),
    .kill_q (kill_q)
  );

  assign rf_we_out = rf_we_in && !pc_load && !kill_q;
endmodule

// File: rtl/exc_vector_unit_chk.sv
module exc_vector_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] pc_now,
  input logic        decode_stb,
  input logic        exec_stb,
  input logic        pc_load,
  input logic [31:0] pc_target,
  input logic        rf_we_out,
  input logic [31:0] epc,
  input logic [31:0] cause
);
  assert_target_R2_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |-> (pc_target == 32'hC000_0000 || pc_target == 32'hC000_0020));

  assert_epc_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |=> (epc == $past(pc_now) - 32'd4));

  assert_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |=> (cause[0] == ($past(pc_target) == 32'hC000_0020)));

  assert_upper_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cause[31:1] == 31'd0);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !pc_load |=> ($stable(epc) && $stable(cause)));

  assert_kill_now_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |-> !rf_we_out);

  assert_kill_next_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |=> !rf_we_out);

  assert_quiet_R6_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!decode_stb && !exec_stb) |-> !pc_load);
endmodule

bind exc_vector_unit exc_vector_unit_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pc_now     (pc_now),
  .decode_stb (decode_stb),
  .exec_stb   (exec_stb),
  .pc_load    (pc_load),
  .pc_target  (pc_target),
  .rf_we_out  (rf_we_out),
  .epc        (epc),
  .cause      (cause)
);

// File: tb/sim_exc_vector_unit.sv
module sim_exc_vector_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pc_now = '0;
  logic        decode_stb = 1'b0;
  logic [5:0]  opcode = '0;
  logic        exec_stb = 1'b0;
  logic [1:0]  alu_op = '0;
  logic [31:0] alu_a = '0, alu_b = '0, alu_res = '0;
  logic        rf_we_in = 1'b0;
  logic        pc_load, rf_we_out;
  logic [31:0] pc_target, epc, cause;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  exc_vector_unit u0 (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    decode_stb = 1'b0; exec_stb = 1'b0; alu_op = 2'd0; rf_we_in = 1'b0;
  endtask

  // After a redirect: write blocked for one more cycle, then passes again.
  task automatic after_take(input string tag, input logic [31:0] pc, input logic [31:0] code);
    @(posedge clk); @(negedge clk);
    idle(); rf_we_in = 1'b1; #1;
    chk({tag, " R7 epc"}, epc, pc - 32'd4);
    chk({tag, " R7 cause"}, cause, code);
    chk({tag, " R8 kill next"}, {31'd0, rf_we_out}, 32'd0);
    @(posedge clk); @(negedge clk); #1;
    chk({tag, " R8 release"}, {31'd0, rf_we_out}, 32'd1);
    idle();
  endtask

  task automatic t_reset();
    chk("R1 epc", epc, 32'd0);
    chk("R1 cause", cause, 32'd0);
    chk("R1 load", {31'd0, pc_load}, 32'd0);
  endtask

  task automatic t_badop(input logic [31:0] pc, input logic [5:0] op);
    @(negedge clk);
    pc_now = pc; decode_stb = 1'b1; opcode = op; rf_we_in = 1'b1; #1;
    chk("R2 load", {31'd0, pc_load}, 32'd1);
    chk("R2 target", pc_target, 32'hC000_0000);
    chk("R8 kill now", {31'd0, rf_we_out}, 32'd0);
    after_take("R2", pc, 32'd0);
  endtask

  task automatic t_legal(input logic [5:0] op);
    logic [31:0] e0, c0;
    @(negedge clk);
    e0 = epc; c0 = cause;
    pc_now = 32'h0000_1234; decode_stb = 1'b1; opcode = op; #1;
    chk("R3 no load", {31'd0, pc_load}, 32'd0);
    @(posedge clk); @(negedge clk); #1;
    chk("R3 epc held", epc, e0);
    chk("R9 cause held", cause, c0);
    idle();
  endtask

  function automatic logic sgn_ovf(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b);
    longint s;
    if (op == 2'd1) s = longint'($signed(a)) + longint'($signed(b));
    else            s = longint'($signed(a)) - longint'($signed(b));
    return (s > 64'sd2147483647) || (s < -64'sd2147483648);
  endfunction

  task automatic t_alu(input string tag, input logic [1:0] op, input logic stb,
                       input logic [31:0] a, input logic [31:0] b, input logic [31:0] pc);
    logic exp_o;
    @(negedge clk);
    pc_now = pc; exec_stb = stb; alu_op = op; alu_a = a; alu_b = b;
    alu_res = (op == 2'd2) ? a - b : a + b;
    exp_o = stb && (op == 2'd1 || op == 2'd2) && sgn_ovf(op, a, b);
    #1;
    chk({tag, " load"}, {31'd0, pc_load}, {31'd0, exp_o});
    if (exp_o) begin
      chk({tag, " target"}, pc_target, 32'hC000_0020);
      after_take(tag, pc, 32'd1);
    end else begin
      @(posedge clk); @(negedge clk); idle();
    end
  endtask

  task automatic t_gated();
    logic [31:0] e0;
    e0 = epc;
    t_alu("R6 strobe low", 2'd1, 1'b0, 32'h7FFF_FFFF, 32'd1, 32'h200);
    t_alu("R6 op other", 2'd0, 1'b1, 32'h7FFF_FFFF, 32'd1, 32'h200);
    t_alu("R6 op misc", 2'd3, 1'b1, 32'h8000_0000, 32'h8000_0000, 32'h200);
    chk("R6 epc unchanged", epc, e0);
  endtask

  task automatic t_no_strobe();
    @(negedge clk);
    decode_stb = 1'b0; opcode = 6'h3F; #1;
    chk("R10 ignored", {31'd0, pc_load}, 32'd0);
    idle();
  endtask

  task automatic t_both();
    @(negedge clk);
    pc_now = 32'h0000_0F00; decode_stb = 1'b1; opcode = 6'h11;
    exec_stb = 1'b1; alu_op = 2'd1; alu_a = 32'h7FFF_FFFF; alu_b = 32'd1;
    alu_res = 32'h8000_0000; #1;
    chk("R11 target", pc_target, 32'hC000_0000);
    after_take("R11", 32'h0000_0F00, 32'd0);
  endtask

  initial begin
    #2000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1; t_reset();
    rst_n = 1'b1;
    t_badop(32'h0000_0104, 6'h3F);
    t_badop(32'h0040_0010, 6'h01);
    t_legal(6'h00); t_legal(6'h02); t_legal(6'h04); t_legal(6'h23); t_legal(6'h2B);
    t_alu("R4 pos", 2'd1, 1'b1, 32'h7FFF_FFFF, 32'd1, 32'h0000_0300);
    t_alu("R4 neg", 2'd1, 1'b1, 32'h8000_0000, 32'hFFFF_FFFF, 32'h0000_0308);
    t_alu("R4 none", 2'd1, 1'b1, 32'h7FFF_FFFE, 32'd1, 32'h0000_0310);
    t_alu("R5 pos", 2'd2, 1'b1, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0320);
    t_alu("R5 neg", 2'd2, 1'b1, 32'h8000_0000, 32'd1, 32'h0000_0328);
    t_alu("R5 none", 2'd2, 1'b1, 32'hFFFF_FFFF, 32'h8000_0000, 32'h0000_0330);
    t_gated();
    t_no_strobe();
    t_both();
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule